// File: doc/BRIEF.md
# Multi-Stage Battery Charge Sequencer

The block runs one battery charging cycle from digital measurements of battery voltage, charge current and temperature. Each measurement is valid on a one-cycle sample strobe. A start command begins a cycle. The block first charges gently at a fifth of the programmed current until the pack voltage reaches a "normal" floor. It then holds the full programmed current until the voltage reaches the limit setpoint. In the voltage-limited taper that follows, it nudges a digital potentiometer step by step so that the current falls. When the current has decayed to a fifth of the setpoint, it drops to a trickle. A seconds timer ends the cycle when the programmed charge time has passed.

The outputs are a current reference code for the regulator, a trim step strobe with a direction bit, a mains relay enable, a latched alarm, a sleep flag and the stage code. The alarm fires when any measurement exceeds its setpoint by more than one tenth. It opens the relay and stays latched until reset. The sleep flag follows whether the last sampled current was zero.

Top module: `chg_seq`

## Requirements
- R1: After reset, stage_o is 0 (idle), relay_o, alarm_o, sleep_o and trim_step_o are 0 and iref_o is 0.
- R2: A start_i pulse in idle moves to stage 1 (precharge) with relay_o high and iref_o = floor(iset_i/5). The block stays in stage 1 while sampled vbat_i < vnorm_i.
- R3: In stage 1 a sample with vbat_i >= vnorm_i moves to stage 2 (constant current), where iref_o = iset_i.
- R4: In stage 2 a sample with vbat_i >= vlim_i moves to stage 3 (taper), where iref_o stays iset_i. A start_i pulse while charging has no effect.
- R5: In stage 3, each sample that does not end the taper produces a one-cycle trim_step_o pulse. trim_up_o is 1 (raise resistance) when vbat_i >= vlim_i and 0 otherwise. trim_step_o is high only in the cycle after a strobe.
- R6: In stage 3 a sample with ibat_i <= floor(iset_i/5) moves to stage 4 (trickle), with iref_o = floor(iset_i/5) and no trim pulse.
- R7: A seconds counter ticks once every TICK_DIV clocks while stages 1 to 4 are active, starting from zero at precharge entry. Once the count reaches tset_i, the stage becomes 5 (done), with relay_o low and iref_o 0.
- R8: While charging, a sample with vbat_i > vlim_i + floor(vlim_i/10), ibat_i > iset_i + floor(iset_i/10) or temp_i > tmax_i + floor(tmax_i/10) sets alarm_o and stage 6 (fault) in the next cycle, with relay_o low and iref_o 0. Values equal to the bound do not trip.
- R9: alarm_o and stage 6 remain until rst_ni. start_i and samples do not clear them.
- R10: A sample with ibat_i = 0 sets sleep_o and a nonzero sample clears it. Without a strobe, sleep_o does not change.
- R11: A start_i pulse in stage 5 restarts at stage 1 with the seconds counter cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a charge cycle |
| smp_vld_i | input | 1 | One-cycle strobe: measurements valid |
| vbat_i | input | MW | Battery voltage code |
| ibat_i | input | MW | Charge current code |
| temp_i | input | MW | Temperature code |
| iset_i | input | MW | Programmed charge current |
| vlim_i | input | MW | Limit voltage |
| vnorm_i | input | MW | Lower bound of the normal voltage range |
| tmax_i | input | MW | Temperature setpoint |
| tset_i | input | TW | Charge time in seconds |
| iref_o | output | MW | Current reference code |
| trim_step_o | output | 1 | One-cycle potentiometer step request |
| trim_up_o | output | 1 | Step direction, 1 = more resistance |
| relay_o | output | 1 | Mains relay enable |
| alarm_o | output | 1 | Latched overrange alarm |
| sleep_o | output | 1 | Zero-current indication |
| stage_o | output | 3 | Stage code (0 idle, 1 precharge, 2 CC, 3 taper, 4 trickle, 5 done, 6 fault) |

## Verification
The bound checker watches, on every cycle, the properties that need no stimulus history. These are that the alarm and the fault stage hold, that an alarm excludes the relay, that a trim pulse only follows a strobe, that sleep only moves on a strobe, that the done stage is quiet and that the constant-current stage drives the full setpoint. The stage order, the threshold boundaries (floor ratios, equal-to-bound not tripping), the trim direction and the timer length are shown only by the bench's directed scenarios. In each of those scenarios the bench computes the expected codes from the setpoints.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_CC    = 3'd2,
    ST_TAPER = 3'd3,
    ST_TRKL  = 3'd4,
    ST_DONE  = 3'd5,
    ST_FAULT = 3'd6
  } stage_e;
endpackage

// File: rtl/chg_timer.sv
module chg_timer #(
  parameter int TICK_DIV = 1000,
  parameter int TW       = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pre_q;
  logic [TW-1:0] sec_q;
  logic          tick;

  assign tick = (pre_q == PW'(TICK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      sec_q <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
      sec_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick && sec_q != '1) sec_q <= sec_q + 1'b1;
    end
  end

  assign expired_o = run_i && (sec_q >= limit_i);
endmodule

// File: rtl/chg_fault.sv
module chg_fault #(
  parameter int MW = 10
) (
  input  logic [MW-1:0] vbat_i,
  input  logic [MW-1:0] ibat_i,
  input  logic [MW-1:0] temp_i,
  input  logic [MW-1:0] vlim_i,
  input  logic [MW-1:0] iset_i,
  input  logic [MW-1:0] tmax_i,
  output logic          over_o
);
  localparam int EW = MW + 1;

  logic [EW-1:0] bound [3];
  logic [MW-1:0] meas  [3];
  logic [MW-1:0] setp  [3];
  logic [2:0]    hit;

  always_comb begin
    meas[0] = vbat_i; setp[0] = vlim_i;
    meas[1] = ibat_i; setp[1] = iset_i;
    meas[2] = temp_i; setp[2] = tmax_i;
  end

  for (genvar k = 0; k < 3; k++) begin : g_chk
    // setpoint plus one tenth, one bit wider so it cannot wrap
    assign bound[k] = {1'b0, setp[k]} + EW'(setp[k] / MW'(10));
    assign hit[k]   = {1'b0, meas[k]} > bound[k];
  end

  assign over_o = |hit;
endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
  import chg_pkg::*;
#(
  parameter int MW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          smp_vld_i,
  input  logic [MW-1:0] vbat_i,
  input  logic [MW-1:0] ibat_i,
  input  logic [MW-1:0] iset_i,
  input  logic [MW-1:0] vlim_i,
  input  logic [MW-1:0] vnorm_i,
  input  logic          over_i,
  input  logic          expired_i,
  output logic          run_o,
  output logic [MW-1:0] iref_o,
  output logic          trim_step_o,
  output logic          trim_up_o,
  output logic          relay_o,
  output logic          alarm_o,
  output logic          sleep_o,
  output logic [2:0]    stage_o
);
  stage_e        st_q;
  logic          alarm_q, step_q, up_q, sleep_q;
  logic [MW-1:0] i_low;
  logic          active;

  assign i_low  = iset_i / MW'(5);
  assign active = (st_q == ST_PRE) || (st_q == ST_CC) ||
                  (st_q == ST_TAPER) || (st_q == ST_TRKL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      alarm_q <= 1'b0;
      step_q  <= 1'b0;
      up_q    <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      step_q <= 1'b0;
      if (smp_vld_i) sleep_q <= (ibat_i == '0);
      case (st_q)
        ST_IDLE, ST_DONE: if (start_i) st_q <= ST_PRE;
        ST_FAULT: ;
        default: begin
          // fault beats timer beats stage progress
          if (smp_vld_i && over_i) begin
            st_q    <= ST_FAULT;
            alarm_q <= 1'b1;
          end else if (expired_i) begin
            st_q <= ST_DONE;
          end else if (smp_vld_i) begin
            case (st_q)
              ST_PRE:   if (vbat_i >= vnorm_i) st_q <= ST_CC;
              ST_CC:    if (vbat_i >= vlim_i)  st_q <= ST_TAPER;
              ST_TAPER: begin
                if (ibat_i <= i_low) begin
                  st_q <= ST_TRKL;
                end else begin
                  step_q <= 1'b1;
                  up_q   <= (vbat_i >= vlim_i);
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_PRE, ST_TRKL: iref_o = i_low;
      ST_CC, ST_TAPER: iref_o = iset_i;
      default:         iref_o = '0;
    endcase
  end

  assign run_o       = active;
  assign relay_o     = active;
  assign alarm_o     = alarm_q;
  assign trim_step_o = step_q;
  assign trim_up_o   = up_q;
  assign sleep_o     = sleep_q;
  assign stage_o     = st_q;
endmodule

// File: rtl/chg_seq.sv
module chg_seq #(
  parameter int MW       = 10,
  parameter int TW       = 16,
  parameter int TICK_DIV = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          smp_vld_i,
  input  logic [MW-1:0] vbat_i,
  input  logic [MW-1:0] ibat_i,
  input  logic [MW-1:0] temp_i,
  input  logic [MW-1:0] iset_i,
  input  logic [MW-1:0] vlim_i,
  input  logic [MW-1:0] vnorm_i,
  input  logic [MW-1:0] tmax_i,
  input  logic [TW-1:0] tset_i,
  output logic [MW-1:0] iref_o,
  output logic          trim_step_o,
  output logic          trim_up_o,
  output logic          relay_o,
  output logic          alarm_o,
  output logic          sleep_o,
  output logic [2:0]    stage_o
);
  logic run, expired, over;

  chg_timer #(.TICK_DIV(TICK_DIV), .TW(TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .limit_i   (tset_i),
    .expired_o (expired)
  );

  chg_fault #(.MW(MW)) u_fault (
    .vbat_i (vbat_i),
    .ibat_i (ibat_i),
    .temp_i (temp_i),
    .vlim_i (vlim_i),
    .iset_i (iset_i),
    .tmax_i (tmax_i),
    .over_o (over)
  );

  chg_fsm #(.MW(MW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .smp_vld_i   (smp_vld_i),
    .vbat_i      (vbat_i),
    .ibat_i      (ibat_i),
    .iset_i      (iset_i),
    .vlim_i      (vlim_i),
    .vnorm_i     (vnorm_i),
    .over_i      (over),
    .expired_i   (expired),
    .run_o       (run),
    .iref_o      (iref_o),
    .trim_step_o (trim_step_o),
    .trim_up_o   (trim_up_o),
    .relay_o     (relay_o),
    .alarm_o     (alarm_o),
    .sleep_o     (sleep_o),
    .stage_o     (stage_o)
  );
endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk #(
  parameter int MW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          smp_vld_i,
  input logic [MW-1:0] iset_i,
  input logic [MW-1:0] iref_o,
  input logic          trim_step_o,
  input logic          relay_o,
  input logic          alarm_o,
  input logic          sleep_o,
  input logic [2:0]    stage_o
);
  p_cc_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o == 3'd2 |-> iref_o == iset_i);

  p_trim_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trim_step_o |-> $past(smp_vld_i));

  p_done_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o == 3'd5 |-> !relay_o && iref_o == '0);

  p_alarm_open_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> !relay_o && stage_o == 3'd6);

  p_alarm_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |=> alarm_o);

  p_fault_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o == 3'd6 |=> stage_o == 3'd6);

  p_sleep_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> $stable(sleep_o));
endmodule

bind chg_seq chg_seq_chk #(.MW(MW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_vld_i   (smp_vld_i),
  .iset_i      (iset_i),
  .iref_o      (iref_o),
  .trim_step_o (trim_step_o),
  .relay_o     (relay_o),
  .alarm_o     (alarm_o),
  .sleep_o     (sleep_o),
  .stage_o     (stage_o)
);

// File: tb/chg_seq_test.sv
`timescale 1ns/1ps
module chg_seq_test;
  localparam int MW = 10;
  localparam int TW = 8;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, vld = 1'b0;
  logic [MW-1:0] vbat = '0, ibat = '0, temp = '0;
  logic [MW-1:0] iset = 10'd500, vlim = 10'd400, vnorm = 10'd300, tmax = 10'd200;
  logic [TW-1:0] tset = 8'd200;
  logic [MW-1:0] iref;
  logic step, up, relay, alarm, sleep;
  logic [2:0] stage;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chg_seq #(.MW(MW), .TW(TW), .TICK_DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .smp_vld_i(vld),
    .vbat_i(vbat), .ibat_i(ibat), .temp_i(temp), .iset_i(iset),
    .vlim_i(vlim), .vnorm_i(vnorm), .tmax_i(tmax), .tset_i(tset),
    .iref_o(iref), .trim_step_o(step), .trim_up_o(up), .relay_o(relay),
    .alarm_o(alarm), .sleep_o(sleep), .stage_o(stage)
  );

  task automatic chk(input int act, input int exp, input string what);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; vld = 1'b0; start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic sample(input int v, input int i, input int t);
    @(negedge clk);
    vbat = MW'(v); ibat = MW'(i); temp = MW'(t); vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(stage, 0, "R1 stage");
    chk(relay, 0, "R1 relay");
    chk(alarm, 0, "R1 alarm");
    chk(sleep, 0, "R1 sleep");
    chk(step, 0, "R1 trim");
    chk(iref, 0, "R1 iref");
  endtask

  task automatic t_cycle();
    do_reset(); tset = 8'd200;
    pulse_start();
    chk(stage, 1, "R2 stage"); chk(relay, 1, "R2 relay"); chk(iref, 100, "R2 iref");
    sample(250, 100, 50);
    chk(stage, 1, "R2 hold below floor");
    sample(300, 100, 50);
    chk(stage, 2, "R3 stage"); chk(iref, 500, "R3 iref");
    pulse_start();
    chk(stage, 2, "R4 start ignored");
    sample(380, 500, 60);
    chk(stage, 2, "R4 below limit");
    sample(400, 480, 60);
    chk(stage, 3, "R4 stage"); chk(iref, 500, "R4 iref"); chk(step, 0, "R5 no step on entry");
    sample(405, 400, 60);
    chk(step, 1, "R5 step"); chk(up, 1, "R5 up");
    @(negedge clk);
    chk(step, 0, "R5 one cycle");
    sample(395, 300, 60);
    chk(step, 1, "R5 step down"); chk(up, 0, "R5 down");
    sample(400, 100, 60);
    chk(stage, 4, "R6 stage"); chk(iref, 100, "R6 iref"); chk(step, 0, "R6 no step");
    sample(390, 0, 60);
    chk(sleep, 1, "R10 sleep");
    repeat (3) @(negedge clk);
    chk(sleep, 1, "R10 hold");
    sample(390, 50, 60);
    chk(sleep, 0, "R10 wake");
  endtask

  task automatic t_timer();
    do_reset(); tset = 8'd3;
    pulse_start();
    repeat (8) @(negedge clk);
    chk(stage, 1, "R7 before expiry");
    repeat (12) @(negedge clk);
    chk(stage, 5, "R7 done"); chk(relay, 0, "R7 relay"); chk(iref, 0, "R7 iref");
    pulse_start();
    chk(stage, 1, "R11 restart"); chk(relay, 1, "R11 relay");
    repeat (8) @(negedge clk);
    chk(stage, 1, "R11 timer cleared");
    tset = 8'd200;
  endtask

  task automatic t_faults();
    do_reset(); tset = 8'd200;
    pulse_start();
    sample(440, 100, 50);
    chk(alarm, 0, "R8 volt at bound"); chk(stage, 2, "R8 volt at bound stage");
    sample(441, 100, 50);
    chk(alarm, 1, "R8 volt alarm"); chk(relay, 0, "R8 relay"); chk(stage, 6, "R8 fault");
    chk(iref, 0, "R8 iref");
    pulse_start();
    sample(300, 100, 50);
    chk(alarm, 1, "R9 alarm held"); chk(stage, 6, "R9 stage held");

    do_reset();
    pulse_start();
    sample(320, 550, 50);
    chk(alarm, 0, "R8 current at bound");
    sample(320, 551, 50);
    chk(alarm, 1, "R8 current alarm");

    do_reset();
    pulse_start();
    sample(250, 100, 220);
    chk(alarm, 0, "R8 temp at bound");
    sample(250, 100, 221);
    chk(alarm, 1, "R8 temp alarm"); chk(relay, 0, "R8 temp relay");
    do_reset();
    chk(alarm, 0, "R9 cleared by reset");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cycle();
    t_timer();
    t_faults();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule